// File: doc/BRIEF.md
# Double-Buffered Serial DAC Code Register

This block is the digital front end of a 12-bit multiplying converter. A three-wire serial port delivers the code: a serial clock, a data line and an active-low load strobe. On each rising serial-clock edge the data bit enters a shift register, most significant bit first. A second register, the converter code register, drives the resistor ladder. It takes the shift register's contents for as long as load is held low and keeps its value while load is high. The writer can therefore shift a new code in without disturbing the output, then update the output with one strobe.

The three serial pins are asynchronous to the system clock. Each passes through a synchronizer and is sampled by the 50 MHz system clock. A serial-clock edge is found by comparing successive synchronized samples. The shift register and the code register are system-clock flops, so the transparent phase of the code register has a latency of a few system cycles. An active-low clear input zeroes both registers at once, with no clock edge needed, and holds them at zero while it stays low. The synchronous power-on reset also zeroes them. The shift register's contents are also brought out as a debug view.

Top module: `dac_fe_top`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, `dac_code` and `shift_view` become 0 and stay 0 until data is shifted in and loaded.
- R2: Each rising edge of `sclk` shifts the value of `sdi` into bit 0 of the shift register, and the older bits move one place toward bit 11. After twelve bits, the first bit sent is at bit 11 of `shift_view` and the last is at bit 0. `shift_view` changes no later than 3 `clk` cycles after the rising `sclk` edge.
- R3: When `load_n` goes low, `dac_code` takes the shift register's value no later than 3 `clk` cycles later.
- R4: While `load_n` is high, `dac_code` keeps its value, even while new bits are being shifted in.
- R5: If more than 12 bits are clocked in before a load, only the last 12 bits remain in the shift register.
- R6: Rising `sclk` edges while `load_n` is low keep shifting, and `dac_code` follows each new shift register value within one further `clk` cycle.
- R7: Driving `clr_n` low clears `dac_code` and `shift_view` to 0 at once, without any `clk` edge.
- R8: While `clr_n` is low, `sclk` edges and `load_n` pulses have no effect: both outputs stay 0, and they are still 0 just after `clr_n` returns high.
- R9: Serial clock high and low phases of 2 `clk` cycles each are captured with no lost or duplicated bit. At the 50 MHz system clock this is a 12.5 MHz serial clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (50 MHz) |
| rst | input | 1 | Synchronous active-high power-on reset |
| sclk | input | 1 | Serial clock, asynchronous; data taken on its rising edge |
| sdi | input | 1 | Serial data, most significant bit first |
| load_n | input | 1 | Active-low load strobe; the code register follows the shift register while it is low |
| clr_n | input | 1 | Active-low asynchronous clear of both registers |
| dac_code | output | 12 | Code driving the converter ladder |
| shift_view | output | 12 | Debug view of the shift register |

## Verification
Directed words that share no bit pattern with their neighbours, such as 0xA5C, 0xFFF and 0x001, show a reversed bit order or a lost bit in `shift_view`. They also show a load that fails to copy, or copies at the wrong time. Longer frames of 16 and 13 bits tell a register that keeps the last 12 bits from one that stops at 12. Shifting with `load_n` held low tells a true follow-through from a one-shot copy on the strobe. Random words of 12 to 20 bits, all at the fastest serial rate, are compared with a bench shift model. A clear applied between clock edges, with shifting and loading attempted during it, tells an asynchronous, blocking clear from a synchronous or leaky one.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

    localparam int CODE_W_DEF = 12;
    localparam int SYNC_STAGES_DEF = 2;

    typedef struct packed {
        logic sclk;
        logic sdi;
        logic load_n;
    } pins_t;

    localparam pins_t PINS_IDLE = '{sclk: 1'b0, sdi: 1'b0, load_n: 1'b1};

    function automatic logic rising(input logic prev, input logic cur);
        return cur & ~prev;
    endfunction

endpackage

// File: rtl/dac_fe_sync.sv
module dac_fe_sync
    import dac_fe_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES_DEF
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t raw,
    output pins_t q,
    output logic  sclk_rise
);

    pins_t chain [STAGES];
    logic  sclk_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                chain[i] <= PINS_IDLE;
            end
            sclk_last <= 1'b0;
        end else begin
            chain[0] <= raw;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
            sclk_last <= chain[STAGES-1].sclk;
        end
    end

    assign q         = chain[STAGES-1];
    assign sclk_rise = rising(sclk_last, chain[STAGES-1].sclk);

endmodule

// File: rtl/dac_fe_shift.sv
module dac_fe_shift #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_n,
    input  logic         step,
    input  logic         bit_in,
    output logic [W-1:0] sreg
);

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            sreg <= '0;
        end else if (rst) begin
            sreg <= '0;
        end else if (step) begin
            sreg <= {sreg[W-2:0], bit_in};
        end
    end

endmodule

// File: rtl/dac_fe_hold.sv
module dac_fe_hold #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_n,
    input  logic         open_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            dout <= '0;
        end else if (rst) begin
            dout <= '0;
        end else if (!open_n) begin
            dout <= din;
        end
    end

endmodule

// File: rtl/dac_fe_top.sv
module dac_fe_top
    import dac_fe_pkg::*;
#(
    parameter int CODE_W      = CODE_W_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              load_n,
    input  logic              clr_n,
    output logic [CODE_W-1:0] dac_code,
    output logic [CODE_W-1:0] shift_view
);

    pins_t             pins_raw;
    pins_t             pins_q;
    logic              sclk_rise;
    logic              sdi_q;
    logic              load_q_n;
    logic [CODE_W-1:0] sreg;
    logic [CODE_W-1:0] code_reg;

    assign pins_raw = '{sclk: sclk, sdi: sdi, load_n: load_n};
    assign sdi_q    = pins_q.sdi;
    assign load_q_n = pins_q.load_n;

    dac_fe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .raw       (pins_raw),
        .q         (pins_q),
        .sclk_rise (sclk_rise)
    );

    dac_fe_shift #(.W(CODE_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .clr_n  (clr_n),
        .step   (sclk_rise),
        .bit_in (sdi_q),
        .sreg   (sreg)
    );

    dac_fe_hold #(.W(CODE_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .clr_n  (clr_n),
        .open_n (load_q_n),
        .din    (sreg),
        .dout   (code_reg)
    );

    assign dac_code   = code_reg;
    assign shift_view = sreg;

endmodule

// File: rtl/dac_fe_chk.sv
module dac_fe_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst,
    input logic         clr_n,
    input logic         load_q_n,
    input logic         rise,
    input logic         sdi_q,
    input logic [W-1:0] sreg,
    input logic [W-1:0] code
);

    // R2: a detected serial edge shifts the synchronized data bit in at bit 0
    p_shift_step_r2: assert property (@(posedge clk) disable iff (rst || !clr_n)
        rise |=> (sreg == {$past(sreg[W-2:0]), $past(sdi_q)}));

    // R2: no serial edge, no change of the shift register
    p_shift_idle_r2: assert property (@(posedge clk) disable iff (rst || !clr_n)
        !rise |=> $stable(sreg));

    // R4: load high keeps the code register
    p_hold_r4: assert property (@(posedge clk) disable iff (rst || !clr_n)
        load_q_n |=> $stable(code));

    // R6: load low makes the code register follow the shift register
    p_follow_r6: assert property (@(posedge clk) disable iff (rst || !clr_n)
        !load_q_n |=> (code == $past(sreg)));

    // R8: clear held low keeps both registers at zero
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> (code == '0 && sreg == '0));

endmodule

bind dac_fe_top dac_fe_chk #(.W(CODE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr_n    (clr_n),
    .load_q_n (load_q_n),
    .rise     (sclk_rise),
    .sdi_q    (sdi_q),
    .sreg     (sreg),
    .code     (code_reg)
);

// File: tb/tb_dac_fe_top.sv
module tb_dac_fe_top;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sclk = 1'b0;
    logic         sdi = 1'b0;
    logic         load_n = 1'b1;
    logic         clr_n = 1'b1;
    logic [W-1:0] dac_code;
    logic [W-1:0] shift_view;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [W-1:0] m_shift = '0;
    logic [W-1:0] m_code  = '0;

    always #10 clk = ~clk;

    dac_fe_top dut (
        .clk        (clk),
        .rst        (rst),
        .sclk       (sclk),
        .sdi        (sdi),
        .load_n     (load_n),
        .clr_n      (clr_n),
        .dac_code   (dac_code),
        .shift_view (shift_view)
    );

    function automatic logic [W-1:0] model_shift(input logic [W-1:0] cur, input logic b);
        return {cur[W-2:0], b};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bit at the fastest rate: 2 clk high, 2 clk low (R9)
    task automatic send_bit(input logic b, input bit track);
        sdi  = b;
        sclk = 1'b1;
        tick(2);
        sclk = 1'b0;
        tick(2);
        if (track) m_shift = model_shift(m_shift, b);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            send_bit(v[i], 1'b1);
        end
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        tick(4);
        load_n = 1'b1;
        tick(4);
        m_code = m_shift;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 12'h0, 12'h1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd5521));
        tick(5);
        rst = 1'b0;
        tick(1);
        // R1: reset state
        check("R1 code after reset", dac_code, 12'h000);
        check("R1 shift after reset", shift_view, 12'h000);

        // R2, R4: shift in with load high, code holds
        send_bits(32'hA5C, 12);
        check("R2 msb first 0xA5C", shift_view, 12'hA5C);
        check("R4 code held during shift", dac_code, 12'h000);
        // R3: load copies
        pulse_load();
        check("R3 load copies 0xA5C", dac_code, 12'hA5C);

        send_bits(32'h001, 12);
        check("R2 msb first 0x001", shift_view, 12'h001);
        check("R4 code keeps 0xA5C", dac_code, 12'hA5C);
        pulse_load();
        check("R3 load copies 0x001", dac_code, 12'h001);

        send_bits(32'hFFF, 12);
        pulse_load();
        check("R3 load copies 0xFFF", dac_code, 12'hFFF);

        // R5: overlong frames keep last 12 bits
        send_bits(32'h3C96, 16);
        check("R5 16 bits keep last 12", shift_view, 12'hC96);
        send_bits(32'h1234, 13);
        check("R5 13 bits keep last 12", shift_view, 12'h234);
        pulse_load();
        check("R5 loaded last 12", dac_code, 12'h234);

        // R6: transparent while load low
        load_n = 1'b0;
        tick(4);
        for (int i = 0; i < 6; i++) begin
            send_bit(i[0] ^ i[1], 1'b1);
            check("R6 code follows shift", dac_code, m_shift);
        end
        load_n = 1'b1;
        tick(4);
        m_code = m_shift;
        send_bits(32'h0F0, 12);
        check("R4 code held after transparent phase", dac_code, m_code);

        // R7: asynchronous clear between edges
        #3;
        clr_n = 1'b0;
        #1;
        check("R7 code cleared at once", dac_code, 12'h000);
        check("R7 shift cleared at once", shift_view, 12'h000);
        tick(1);
        // R8: shifting and loading blocked during clear
        send_bits(32'hBEE, 12);
        load_n = 1'b0;
        tick(4);
        load_n = 1'b1;
        tick(4);
        check("R8 shift blocked in clear", shift_view, 12'h000);
        check("R8 load blocked in clear", dac_code, 12'h000);
        clr_n = 1'b1;
        tick(2);
        check("R8 shift zero after release", shift_view, 12'h000);
        check("R8 code zero after release", dac_code, 12'h000);
        m_shift = '0;
        m_code  = '0;

        // R1: reset mid-operation
        send_bits(32'h777, 12);
        pulse_load();
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(1);
        check("R1 code after second reset", dac_code, 12'h000);
        check("R1 shift after second reset", shift_view, 12'h000);
        m_shift = '0;
        m_code  = '0;

        // R9: random frames at the fastest serial rate
        for (int k = 0; k < 24; k++) begin
            logic [31:0] v;
            int          n;
            v = $urandom;
            n = 12 + int'($urandom % 9);
            send_bits(v, n);
            check("R9 random shift", shift_view, m_shift);
            if ($urandom % 2 == 1) begin
                pulse_load();
            end
            check("R9 random code", dac_code, m_code);
        end

        finish_run();
    end

endmodule